// File: doc/BRIEF.md
# Memory-Mapped Target Decoder

This block sits between a CPU's 16-bit word-addressed bus and four memory-mapped targets: a read-only boot ROM, a single-word output port that only takes writes, a four-word framebuffer control window, and a general RAM. Each request is matched against a fixed, irregular address map. When the address lands in a region that allows the requested direction, exactly one target select rises for the cycle the request is taken. The target receives the address minus its region base as its local offset, together with the write flag and the write data, passed through unchanged.

Requests arrive on a valid/ready channel. A request is taken in a cycle where `req_valid` and `req_ready` are both high. One cycle later a response appears on a valid/ready response channel, carrying the read data and an error flag. The response register holds a single entry, so `req_ready` is high when that register is empty or when the CPU takes the pending response in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While a response waits for `rsp_ready`, no new request is taken and no target is selected. The response data and error stay stable for as long as the response waits.

Targets present read data combinationally, in the same cycle they are selected. The decoder captures that data into the response register. Writes, and any access that faults, return 0x0000.

Top module: `memmap_decoder`

## Requirements
- R1: A read from 0x0000..0x3FFF raises `tgt_sel[0]` (ROM) with `tgt_offset` equal to the address. It returns that target's read data with `rsp_err` low.
- R2: A write into 0x0000..0x3FFF selects no target and returns `rsp_err` high.
- R3: A write to 0x4000 raises `tgt_sel[1]` (output port) with offset 0. `tgt_write` is high and `tgt_wdata` equals `req_wdata`.
- R4: A read from 0x4000 selects no target and returns `rsp_err` high with `rsp_rdata` 0x0000.
- R5: A read or write in 0x4100..0x4103 raises `tgt_sel[2]` (framebuffer window) with offset equal to the address minus 0x4100, and without error.
- R6: A read or write in 0x8000..0xFFFF raises `tgt_sel[3]` (RAM) with offset equal to the address minus 0x8000, and without error.
- R7: Any other address, for example 0x4001, 0x40FF, 0x4104 or 0x7FFF, selects no target in either direction and returns `rsp_err` high with `rsp_rdata` 0x0000.
- R8: At most one `tgt_sel` bit is high at a time, and only in a cycle where a request is taken. `tgt_write` matches `req_write`.
- R9: The response is valid in the cycle after the request is taken. A response waiting on low `rsp_ready` keeps `rsp_rdata` and `rsp_err` stable, holds `req_ready` low, and keeps all selects low. A write without error returns data 0x0000.
- R10: During reset and right after it, `rsp_valid` is low and no target is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_rdata | output | 16 | Read data; 0x0000 on writes and faults |
| rsp_err | output | 1 | Access fault (unmapped address or wrong direction) |
| tgt_sel | output | 4 | One-hot target select: bit0 ROM, bit1 output port, bit2 framebuffer window, bit3 RAM |
| tgt_write | output | 1 | Direction forwarded to the selected target |
| tgt_offset | output | 16 | Address minus the base of the selected region |
| tgt_wdata | output | 16 | Write data forwarded unchanged |
| tgt_rdata | input | 64 | Read data of all targets, 16 bits each, target i in bits [16i+15:16i] |

## Verification
A region mask or base that is wrong shows up in the same cycle as a wrong `tgt_sel` bit or a wrong `tgt_offset`. The bench therefore probes each region edge and the gaps between the regions. A wrong permission bit shows up at the ports in two ways: a select rises where none should, and one cycle later `rsp_err` is wrong in the response. A fault in the response register shows up one cycle after the request is taken, as missing or extra `rsp_valid` or as read data that changes while the response waits. Holding `rsp_ready` low across several cycles exposes it.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int NUM_TGT = 4;

  // target index order is the tgt_sel bit order
  typedef enum logic [1:0] {
    TGT_ROM = 2'd0,
    TGT_OUT = 2'd1,
    TGT_FBW = 2'd2,
    TGT_RAM = 2'd3
  } tgt_e;

  // region bases (naturally aligned to their power-of-two size)
  localparam logic [ADDR_W-1:0] TGT_BASE [NUM_TGT] = '{16'h0000, 16'h4000, 16'h4100, 16'h8000};
  // log2 of region size in words
  localparam int TGT_LOG2 [NUM_TGT] = '{14, 0, 2, 15};
  // direction permissions, bit i = target i
  localparam logic [NUM_TGT-1:0] RD_PERM = 4'b1101;
  localparam logic [NUM_TGT-1:0] WR_PERM = 4'b1110;
endpackage

// File: rtl/region_decode.sv
module region_decode
  import memmap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NT = NUM_TGT
) (
  input  logic [AW-1:0] addr,
  output logic [NT-1:0] hit,
  output logic [AW-1:0] offset
);
  logic [AW-1:0] off_part [NT];

  for (genvar i = 0; i < NT; i++) begin : g_region
    localparam logic [AW-1:0] SPAN = AW'(1) << TGT_LOG2[i];
    localparam logic [AW-1:0] MASK = ~(SPAN - AW'(1));
    localparam logic [AW-1:0] BASE = AW'(TGT_BASE[i]);
    assign hit[i]      = (addr & MASK) == BASE;
    assign off_part[i] = hit[i] ? (addr - BASE) : '0;
  end

  // regions are disjoint, so at most one part is nonzero
  always_comb begin
    offset = '0;
    for (int i = 0; i < NT; i++) offset |= off_part[i];
  end
endmodule

// File: rtl/access_check.sv
module access_check
  import memmap_pkg::*;
#(
  parameter int NT = NUM_TGT
) (
  input  logic [NT-1:0] hit,
  input  logic          is_write,
  input  logic          fire,
  output logic [NT-1:0] sel,
  output logic          fault
);
  logic [NT-1:0] perm;
  logic [NT-1:0] granted;

  assign perm    = is_write ? WR_PERM[NT-1:0] : RD_PERM[NT-1:0];
  assign granted = hit & perm;
  assign sel     = fire ? granted : '0;
  assign fault   = ~|granted;
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage
  import memmap_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NT = NUM_TGT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           fault,
  input  logic           is_write,
  input  logic [NT-1:0]  sel,
  input  logic [NT*DW-1:0] tgt_rdata,
  input  logic           rsp_ready,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_err
);
  logic [DW-1:0] rmux;

  always_comb begin
    rmux = '0;
    if (!is_write) begin
      for (int i = 0; i < NT; i++)
        if (sel[i]) rmux |= tgt_rdata[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rmux;
      rsp_err   <= fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NT = NUM_TGT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic [NT-1:0]    tgt_sel,
  output logic             tgt_write,
  output logic [AW-1:0]    tgt_offset,
  output logic [DW-1:0]    tgt_wdata,
  input  logic [NT*DW-1:0] tgt_rdata
);
  logic [NT-1:0] hit;
  logic          fire;
  logic          fault;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign tgt_write = req_write;
  assign tgt_wdata = req_wdata;

  region_decode #(.AW(AW), .NT(NT)) u_dec (
    .addr   (req_addr),
    .hit    (hit),
    .offset (tgt_offset)
  );

  access_check #(.NT(NT)) u_chk (
    .hit      (hit),
    .is_write (req_write),
    .fire     (fire),
    .sel      (tgt_sel),
    .fault    (fault)
  );

  rsp_stage #(.DW(DW), .NT(NT)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fault     (fault),
    .is_write  (req_write),
    .sel       (tgt_sel),
    .tgt_rdata (tgt_rdata),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/memmap_decoder_sva.sv
module memmap_decoder_sva #(
  parameter int DW = 16,
  parameter int NT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic [NT-1:0] tgt_sel,
  input logic          tgt_write
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel)); // R8
  AST_SEL_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel != '0) |-> (req_valid && req_ready)); // R8
  AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[0] |-> !tgt_write); // R2
  AST_OUT_NEVER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[1] |-> tgt_write); // R4
  AST_UNSELECTED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tgt_sel == '0) |=> (rsp_valid && rsp_err)); // R7
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R9
  AST_STALL_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (tgt_sel == '0)); // R9
endmodule

bind memmap_decoder memmap_decoder_sva #(.DW(DW), .NT(NT)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .tgt_sel   (tgt_sel),
  .tgt_write (tgt_write)
);

// File: tb/sim_memmap_decoder.sv
`timescale 1ns/1ps
module sim_memmap_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  tgt_sel;
  logic        tgt_write;
  logic [15:0] tgt_offset;
  logic [15:0] tgt_wdata;
  logic [63:0] tgt_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // target models: data is a tag xor the offset they see
  assign tgt_rdata = {tgt_offset ^ 16'h5000, tgt_offset ^ 16'hC000,
                      16'hDEAD, tgt_offset ^ 16'hA000};

  memmap_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tgt_sel(tgt_sel), .tgt_write(tgt_write), .tgt_offset(tgt_offset),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // one access with response taken at once
  task automatic do_access(input logic [15:0] a, input bit w, input logic [15:0] d,
                           input logic [3:0] esel, input logic [15:0] eoff,
                           input bit eerr, input logic [15:0] erd, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, req, "req_ready", req_ready, 1);
    chk(tgt_sel == esel, req, $sformatf("tgt_sel @%h", a), tgt_sel, esel);
    if (esel != '0) begin
      chk(tgt_offset == eoff, req, $sformatf("offset @%h", a), tgt_offset, eoff);
      chk(tgt_write == w, "R8", "tgt_write", tgt_write, w);
      chk(tgt_wdata == d, req, "tgt_wdata", tgt_wdata, d);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b1, "R9", "rsp_valid", rsp_valid, 1);
    chk(rsp_err == eerr, req, $sformatf("rsp_err @%h", a), rsp_err, eerr);
    chk(rsp_rdata == erd, req, $sformatf("rsp_rdata @%h", a), rsp_rdata, erd);
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R9", "rsp_valid drop", rsp_valid, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", rsp_valid, 0);
    chk(tgt_sel == 4'b0, "R10", "tgt_sel in reset", tgt_sel, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
  endtask

  task automatic t_rom();
    do_access(16'h0000, 1'b0, 16'h0, 4'b0001, 16'h0000, 1'b0, 16'hA000, "R1");
    do_access(16'h3FFF, 1'b0, 16'h0, 4'b0001, 16'h3FFF, 1'b0, 16'h9FFF, "R1");
    do_access(16'h1234, 1'b1, 16'h7777, 4'b0000, 16'h0, 1'b1, 16'h0000, "R2");
  endtask

  task automatic t_out_port();
    do_access(16'h4000, 1'b1, 16'h0039, 4'b0010, 16'h0000, 1'b0, 16'h0000, "R3");
    do_access(16'h4000, 1'b0, 16'h0, 4'b0000, 16'h0, 1'b1, 16'h0000, "R4");
  endtask

  task automatic t_fb();
    do_access(16'h4100, 1'b0, 16'h0, 4'b0100, 16'h0000, 1'b0, 16'hC000, "R5");
    do_access(16'h4103, 1'b1, 16'hBEEF, 4'b0100, 16'h0003, 1'b0, 16'h0000, "R5");
    do_access(16'h4102, 1'b0, 16'h0, 4'b0100, 16'h0002, 1'b0, 16'hC002, "R5");
  endtask

  task automatic t_ram();
    do_access(16'h8000, 1'b1, 16'h1111, 4'b1000, 16'h0000, 1'b0, 16'h0000, "R6");
    do_access(16'hFFFF, 1'b0, 16'h0, 4'b1000, 16'h7FFF, 1'b0, 16'h2FFF, "R6");
    do_access(16'hA5A5, 1'b0, 16'h0, 4'b1000, 16'h25A5, 1'b0, 16'h75A5, "R6");
  endtask

  task automatic t_unmapped();
    do_access(16'h4001, 1'b0, 16'h0, 4'b0000, 16'h0, 1'b1, 16'h0000, "R7");
    do_access(16'h40FF, 1'b1, 16'h2222, 4'b0000, 16'h0, 1'b1, 16'h0000, "R7");
    do_access(16'h4104, 1'b0, 16'h0, 4'b0000, 16'h0, 1'b1, 16'h0000, "R7");
    do_access(16'h7FFF, 1'b1, 16'h3333, 4'b0000, 16'h0, 1'b1, 16'h0000, "R7");
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h8010; req_write = 1'b0;
    @(negedge clk);
    // new request waits behind the pending response
    req_addr = 16'h4102; req_write = 1'b1; req_wdata = 16'h00AB;
    #1;
    chk(rsp_valid == 1'b1, "R9", "rsp_valid stalled", rsp_valid, 1);
    chk(req_ready == 1'b0, "R9", "req_ready stalled", req_ready, 0);
    chk(tgt_sel == 4'b0, "R9", "tgt_sel stalled", tgt_sel, 0);
    held = rsp_rdata;
    chk(held == 16'h5010, "R9", "rsp_rdata stalled", held, 16'h5010);
    repeat (2) @(negedge clk);
    #1;
    chk(rsp_rdata == held && rsp_err == 1'b0, "R9", "rsp held", rsp_rdata, held);
    chk(tgt_sel == 4'b0, "R9", "tgt_sel still stalled", tgt_sel, 0);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R9", "req_ready on take", req_ready, 1);
    chk(tgt_sel == 4'b0100, "R9", "waiting req selected", tgt_sel, 4'b0100);
    chk(tgt_offset == 16'h0002, "R5", "waiting req offset", tgt_offset, 2);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b1 && rsp_rdata == 16'h0000 && rsp_err == 1'b0,
        "R9", "write response", rsp_rdata, 0);
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R9", "rsp drained", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_rom();
    t_out_port();
    t_fb();
    t_ram();
    t_unmapped();
    t_backpressure();
    summary();
    $finish;
  end
endmodule